// File: doc/BRIEF.md
# Converter Host Parallel Port

This block is the device-side controller of a 16-bit parallel host port on an oversampling converter. A host uses one active-low select line and one direction line to fetch conversion results and to load configuration words. Each 24-bit result, with its over-range flag and seven filter flags, is fetched as two 16-bit reads. Each configuration write takes two select cycles: an address word and then a data word. The words that have been written are driven to the converter core as a flat bus.

On the core side, a one-cycle strobe from the decimation filter offers each new result. The block keeps the result in a shadow register, so both halves of one fetch come from the same sample. A result that arrives during a fetch waits in a pending register. The block announces each shadow load with a one-cycle low pulse on the ready output. All logic runs in one clock domain. A synchronous active-low reset clears the block. A falling edge on the resync input discards any result that has been partly or not yet fetched.

The bus is split into input, output and output-enable signals. The three-state pad belongs to the pad ring.

Top module: `cvt_host_port`

## Requirements
- R1: While select is low, a low direction line marks a read cycle and a high one marks a write cycle. `bus_oe` is 1 only while select is low and the direction line is low, and `bus_o` is zero whenever `bus_oe` is 0.
- R2: The first read after a shadow load returns result bits 23:8. The second read returns {result[7:0], overrange, flags[6:0]}, with the overrange flag in bit 7. A third read returns the upper word again. The word pointer advances when select rises at the end of a read.
- R3: A write cycle whose sequencer expects an address stores the bus word as the address. The following write cycle writes its bus word into register `addr` when select rises, but only if `addr` < NREG. Register k appears at `reg_flat[16k+15:16k]`. A data word whose address is out of range changes no register.
- R4: A read cycle that falls between an address word and a data word returns the sequencer to expecting an address. The next write word is then taken as an address.
- R5: When a result is loaded into the shadow register, `drdy_n` is low for exactly the one cycle that follows the load edge.
- R6: A result that arrives after the upper word has been read is held back. The following read still returns the lower word of the old sample. When select rises at the end of that read, the held result is loaded and `drdy_n` pulses.
- R7: A falling edge on `sync_n` resets the word pointer to the upper word, drops any held result and clears the shadow to zero. Results offered while `sync_n` is low are ignored and give no ready pulse. The first result offered after `sync_n` returns high is loaded and pulses `drdy_n`.
- R8: While `rst_n` is low, `bus_oe` is 0 and `drdy_n` is 1. Reset clears every register word to zero and the shadow to zero.
- R9: A result that arrives while no fetch is in progress replaces an unread shadow value, so the newest sample is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous reset, active low, held low keeps reset |
| sync_n | input | 1 | Filter resync, falling edge discards results |
| cs_n | input | 1 | Host select, active low |
| rd_wr_n | input | 1 | Direction: 0 read, 1 write |
| bus_i | input | 16 | Bus value from pad |
| bus_o | output | 16 | Bus value to pad |
| bus_oe | output | 1 | Pad output enable |
| res_valid | input | 1 | One-cycle strobe: new result offered |
| res_data | input | 24 | Result sample |
| res_ovr | input | 1 | Over-range flag of the sample |
| res_flags | input | 7 | Filter status flags of the sample |
| drdy_n | output | 1 | Ready pulse, active low |
| reg_flat | output | 16*NREG | Register file contents to the core |

## Verification
A word pointer stuck on the wrong half, or a shadow loaded mid-fetch, returns the wrong word on the very next read. The bench compares every word read against the expected word at the first sampled cycle of that read. A write sequencer in the wrong state puts a data word into the address slot. That changes `reg_flat` at the wrong register after the second select edge, and the bench checks the flat bus right after each write. A missing or misplaced ready pulse is seen on `drdy_n` one cycle after the load edge.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int WORD_W = 16;
  localparam int RES_W  = 24;
  localparam int FLAG_W = 7;
  localparam int LOW_W  = RES_W - WORD_W;

  typedef enum logic {WS_ADDR = 1'b0, WS_DATA = 1'b1} wseq_e;

  // Upper fetch word of a sample.
  function automatic logic [WORD_W-1:0] pack_hi(input logic [RES_W-1:0] r);
    return r[RES_W-1:LOW_W];
  endfunction

  // Lower fetch word: low result bits, over-range, filter flags.
  function automatic logic [WORD_W-1:0] pack_lo(input logic [RES_W-1:0] r,
                                                input logic ovr,
                                                input logic [FLAG_W-1:0] fl);
    return {r[LOW_W-1:0], ovr, fl};
  endfunction

  function automatic logic addr_ok(input logic [WORD_W-1:0] a, input int n);
    return 32'(a) < 32'(n);
  endfunction
endpackage

// File: rtl/hp_edges.sv
module hp_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_wr_n,
  input  logic sync_n,
  output logic rd_end,
  output logic wr_end,
  output logic rd_live,
  output logic sync_fall
);
  logic cs_q, wr_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      wr_q   <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sync_q <= sync_n;
      if (!cs_n) wr_q <= rd_wr_n;
    end
  end

  assign rd_end    = cs_n & ~cs_q & ~wr_q;
  assign wr_end    = cs_n & ~cs_q & wr_q;
  assign rd_live   = ~cs_n & ~rd_wr_n;
  assign sync_fall = sync_q & ~sync_n;
endmodule

// File: rtl/hp_rd_path.sv
module hp_rd_path
  import hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_ovr,
  input  logic [FLAG_W-1:0] res_flags,
  input  logic              sync_n,
  input  logic              sync_fall,
  input  logic              rd_end,
  input  logic              rd_live,
  output logic [WORD_W-1:0] word_out,
  output logic              rd_ptr,
  output logic              sh_load,
  output logic              drdy_n
);
  logic [RES_W-1:0]  sh_d, pd_d;
  logic              sh_o, pd_o, pd_v;
  logic [FLAG_W-1:0] sh_f, pd_f;
  logic              ptr, drdy_q;
  logic              take, busy, fetch_done, use_new, use_pd;

  assign take       = res_valid & sync_n;
  assign busy       = ptr | rd_live | rd_end;
  assign fetch_done = rd_end & ptr;
  assign use_new    = ~sync_fall & take & (fetch_done | ~busy);
  assign use_pd     = ~sync_fall & fetch_done & ~take & pd_v;
  assign sh_load    = use_new | use_pd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_d <= '0; sh_o <= 1'b0; sh_f <= '0;
      pd_d <= '0; pd_o <= 1'b0; pd_f <= '0; pd_v <= 1'b0;
      ptr <= 1'b0; drdy_q <= 1'b0;
    end else begin
      drdy_q <= sh_load;
      if (sync_fall) begin
        ptr <= 1'b0;
        pd_v <= 1'b0;
        sh_d <= '0; sh_o <= 1'b0; sh_f <= '0;
      end else begin
        if (rd_end) ptr <= ~ptr;
        if (use_new) begin
          sh_d <= res_data; sh_o <= res_ovr; sh_f <= res_flags;
        end else if (use_pd) begin
          sh_d <= pd_d; sh_o <= pd_o; sh_f <= pd_f;
        end
        if (fetch_done) pd_v <= 1'b0;
        else if (take && busy) begin
          pd_d <= res_data; pd_o <= res_ovr; pd_f <= res_flags; pd_v <= 1'b1;
        end
      end
    end
  end

  assign word_out = ptr ? pack_lo(sh_d, sh_o, sh_f) : pack_hi(sh_d);
  assign rd_ptr   = ptr;
  assign drdy_n   = ~drdy_q;
endmodule

// File: rtl/hp_wr_seq.sv
module hp_wr_seq
  import hp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rd_wr_n,
  input  logic [WORD_W-1:0]      bus_i,
  input  logic                   rd_end,
  input  logic                   wr_end,
  output logic                   wr_phase,
  output logic                   reg_we,
  output logic [NREG*WORD_W-1:0] reg_flat
);
  wseq_e             st;
  logic [WORD_W-1:0] cap, addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= WS_ADDR; cap <= '0; addr <= '0;
    end else begin
      if (!cs_n && rd_wr_n) cap <= bus_i;
      if (rd_end) st <= WS_ADDR;
      else if (wr_end) begin
        if (st == WS_ADDR) begin
          addr <= cap;
          st   <= WS_DATA;
        end else begin
          st <= WS_ADDR;
        end
      end
    end
  end

  assign wr_phase = (st == WS_DATA);
  assign reg_we   = wr_end & wr_phase & addr_ok(addr, NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (reg_we && addr == WORD_W'(g)) q <= cap;
    end
    assign reg_flat[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/cvt_host_port.sv
module cvt_host_port
  import hp_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_n,
  input  logic                   cs_n,
  input  logic                   rd_wr_n,
  input  logic [WORD_W-1:0]      bus_i,
  output logic [WORD_W-1:0]      bus_o,
  output logic                   bus_oe,
  input  logic                   res_valid,
  input  logic [RES_W-1:0]       res_data,
  input  logic                   res_ovr,
  input  logic [FLAG_W-1:0]      res_flags,
  output logic                   drdy_n,
  output logic [NREG*WORD_W-1:0] reg_flat
);
  logic              ev_rd_end, ev_wr_end, ev_rd_live, ev_sync_fall;
  logic              ev_sh_load, ev_reg_we, wr_phase, rd_ptr;
  logic [WORD_W-1:0] word_out;

  hp_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .sync_n(sync_n),
    .rd_end(ev_rd_end), .wr_end(ev_wr_end), .rd_live(ev_rd_live),
    .sync_fall(ev_sync_fall)
  );

  hp_rd_path u_rd (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_ovr(res_ovr), .res_flags(res_flags), .sync_n(sync_n),
    .sync_fall(ev_sync_fall), .rd_end(ev_rd_end), .rd_live(ev_rd_live),
    .word_out(word_out), .rd_ptr(rd_ptr), .sh_load(ev_sh_load), .drdy_n(drdy_n)
  );

  hp_wr_seq #(.NREG(NREG)) u_wr (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .bus_i(bus_i),
    .rd_end(ev_rd_end), .wr_end(ev_wr_end), .wr_phase(wr_phase),
    .reg_we(ev_reg_we), .reg_flat(reg_flat)
  );

  assign bus_oe = rst_n & ev_rd_live;
  assign bus_o  = bus_oe ? word_out : '0;
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int NREG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_wr_n,
  input logic             sync_n,
  input logic             bus_oe,
  input logic             drdy_n,
  input logic             rd_ptr,
  input logic             wr_end,
  input logic             wr_phase,
  input logic [NREG*16-1:0] reg_flat
);
  p_oe_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!cs_n && !rd_wr_n));

  p_reg_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_flat) |-> $past(wr_end && wr_phase));

  p_drdy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |=> drdy_n);

  p_load_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |-> !rd_ptr);

  p_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> drdy_n);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert (!bus_oe);
    end
  end
endmodule

bind cvt_host_port hp_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .sync_n(sync_n),
  .bus_oe(bus_oe), .drdy_n(drdy_n), .rd_ptr(rd_ptr), .wr_end(ev_wr_end),
  .wr_phase(wr_phase), .reg_flat(reg_flat)
);

// File: tb/cvt_host_port_tb.sv
module cvt_host_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b1, cs_n = 1'b1, rd_wr_n = 1'b0;
  logic [15:0] bus_i = '0;
  logic [15:0] bus_o;
  logic bus_oe, drdy_n;
  logic res_valid = 1'b0, res_ovr = 1'b0;
  logic [23:0] res_data = '0;
  logic [6:0] res_flags = '0;
  logic [NREG*16-1:0] reg_flat;

  int nchk = 0, nfail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_host_port #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .res_valid(res_valid),
    .res_data(res_data), .res_ovr(res_ovr), .res_flags(res_flags),
    .drdy_n(drdy_n), .reg_flat(reg_flat)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Expected fetch words, written from the packing rule of R2.
  function automatic logic [15:0] hi_w(input logic [23:0] d);
    return d >> 8;
  endfunction
  function automatic logic [15:0] lo_w(input logic [23:0] d, input logic o, input logic [6:0] f);
    return (16'(d & 24'hFF) << 8) | (16'(o) << 7) | 16'(f);
  endfunction

  // Scoreboard monitor: compares each read against the queue head.
  always @(negedge clk) begin
    #1;
    if (cs_n) seen = 1'b0;
    else if (rst_n && !rd_wr_n && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2 unexpected read got=%0h exp=none", bus_o);
      end else begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " read word"}, bus_o, e);
        chk("R1 oe on read", bus_oe, 1'b1);
      end
    end
  end

  task automatic push_result(input logic [23:0] d, input logic o, input logic [6:0] f,
                             input bit exp_rdy, input string req);
    res_valid = 1'b1; res_data = d; res_ovr = o; res_flags = f;
    @(negedge clk);
    res_valid = 1'b0;
    chk({req, " ready pulse"}, drdy_n, !exp_rdy);
    @(negedge clk);
    chk({req, " ready returns high"}, drdy_n, 1'b1);
  endtask

  task automatic host_read(input logic [15:0] e, input string req, output bit rdy);
    exp_q.push_back(e);
    tag_q.push_back(req);
    cs_n = 1'b0; rd_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    rdy = !drdy_n;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] w);
    cs_n = 1'b0; rd_wr_n = 1'b1; bus_i = w;
    @(negedge clk);
    chk("R1 no drive on write", bus_oe, 1'b0);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog got=hung exp=done");
    finish_run();
  end

  initial begin
    bit r;
    logic [NREG*16-1:0] exp_regs;
    // R8: reset state, with a read request held during reset
    cs_n = 1'b0; rd_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 oe in reset", bus_oe, 1'b0);
    chk("R8 ready in reset", drdy_n, 1'b1);
    cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 regs after reset", reg_flat, '0);
    chk("R1 idle oe", bus_oe, 1'b0);

    // R2 / R5: single result, four reads wrap the pointer
    push_result(24'hABCDEF, 1'b1, 7'h15, 1'b1, "R5");
    host_read(hi_w(24'hABCDEF), "R2 upper", r);
    host_read(lo_w(24'hABCDEF, 1'b1, 7'h15), "R2 lower", r);
    host_read(hi_w(24'hABCDEF), "R2 wrap upper", r);
    host_read(lo_w(24'hABCDEF, 1'b1, 7'h15), "R2 wrap lower", r);

    // R9: newest unread result wins
    push_result(24'h123456, 1'b0, 7'h01, 1'b1, "R9");
    push_result(24'h789ABC, 1'b0, 7'h7F, 1'b1, "R9");
    host_read(hi_w(24'h789ABC), "R9 upper", r);
    host_read(lo_w(24'h789ABC, 1'b0, 7'h7F), "R9 lower", r);

    // R6: result during a fetch is held until both halves are read
    push_result(24'h111111, 1'b0, 7'h00, 1'b1, "R6");
    host_read(hi_w(24'h111111), "R6 upper old", r);
    push_result(24'h222222, 1'b1, 7'h02, 1'b0, "R6 held");
    host_read(lo_w(24'h111111, 1'b0, 7'h00), "R6 lower old", r);
    chk("R6 ready after fetch", r, 1'b1);
    host_read(hi_w(24'h222222), "R6 upper new", r);
    host_read(lo_w(24'h222222, 1'b1, 7'h02), "R6 lower new", r);

    // R7: resync discards a half-read sample and ignores results while low
    push_result(24'h333333, 1'b0, 7'h00, 1'b1, "R7");
    host_read(hi_w(24'h333333), "R7 upper before sync", r);
    sync_n = 1'b0;
    @(negedge clk);
    push_result(24'h555555, 1'b0, 7'h00, 1'b0, "R7 ignored");
    sync_n = 1'b1;
    @(negedge clk);
    host_read(16'h0000, "R7 cleared upper", r);
    host_read(16'h0000, "R7 cleared lower", r);
    push_result(24'h444444, 1'b0, 7'h00, 1'b1, "R7 fresh");
    host_read(hi_w(24'h444444), "R7 fresh upper", r);
    host_read(lo_w(24'h444444, 1'b0, 7'h00), "R7 fresh lower", r);

    // R3: address then data; out-of-range address ignored
    host_write(16'd2);
    host_write(16'hBEEF);
    exp_regs = '0;
    exp_regs[2*16 +: 16] = 16'hBEEF;
    chk("R3 reg2 written", reg_flat, exp_regs);
    host_write(16'd9);
    host_write(16'h1234);
    chk("R3 out of range ignored", reg_flat, exp_regs);

    // R4: a read between address and data restarts the sequencer
    host_write(16'd3);
    host_read(hi_w(24'h444444), "R4 read mid write", r);
    host_write(16'd5);
    chk("R4 address word wrote nothing", reg_flat, exp_regs);
    host_write(16'hCAFE);
    exp_regs[5*16 +: 16] = 16'hCAFE;
    chk("R4 reg5 written reg3 untouched", reg_flat, exp_regs);
    host_read(lo_w(24'h444444, 1'b0, 7'h00), "R4 lower", r);

    // R8: reset mid-run clears registers and shadow
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 regs cleared", reg_flat, '0);
    chk("R8 ready high", drdy_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    host_read(16'h0000, "R8 shadow cleared upper", r);
    host_read(16'h0000, "R8 shadow cleared lower", r);

    chk("R2 all reads consumed", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule